// File: doc/BRIEF.md
# Coherent Write-Through Cache Cluster with Bus Snooping

This block gives each of several processors a small direct-mapped cache in front of one shared memory and keeps those caches coherent. Each cache line holds one word. Reads that hit return from the local line. Reads that miss fetch the word from memory over a shared bus and fill the line. Any number of caches may hold clean copies of the same word at the same time.

Every write goes out on the shared bus and into memory, so memory always holds the newest value. On the cycle a write completes, every other cache compares the bus address against its own line and drops its copy if the line matches. The writing cache updates its own copy if it has one. A write that misses does not allocate a line. A round-robin arbiter gives the bus to one processor at a time. A processor holds its request until its cache reports completion.

The shared memory is zero after reset. Word addresses split into an index (low bits, which select the line) and a tag (high bits). With the default parameters the address is 6 bits, the index is 2 bits and there are 4 lines per cache.

Top module: `coh_wt_cluster`

## Requirements
- R1: After reset every line in every cache is invalid, so the first read of any address misses (`cpu_hit`=0) and returns the memory value, which is zero.
- R2: A read miss fills the line with the word from memory. A repeated read of the same address then completes with `cpu_hit`=1 and the same data.
- R3: Two or more caches can hold valid copies of one address at once. Reads by each of them hit after each has filled the line.
- R4: Every write is stored in shared memory when its bus transfer completes. A later read miss by any processor returns the written value.
- R5: When one processor's write completes, every other cache holding that address drops its copy. Their next read of it misses and returns the new value.
- R6: A processor that writes an address it holds keeps its line and updates it. Its next read hits with the written value.
- R7: A write reports `cpu_hit`=1 only if the writer's cache held the address when the request was taken. A write miss does not allocate a line, so the writer's next read of that address misses.
- R8: If another processor's write completes in the same cycle that a local read would hit the same line, the invalidation takes priority. The read is handled as a miss (`cpu_hit`=0) and returns the newly written value.
- R9: Two addresses with the same index and different tags share one line. Reading one after the other replaces the line, and each read misses.
- R10: At most one processor owns the bus in any cycle. Requests are granted in round-robin order, and a requesting cache keeps its request and command steady until memory acknowledges it. Processors that request at the same time all complete.
- R11: A write to an address whose tag differs from the tag held in another cache's line, at the same index, leaves that line valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | NCPU | Per-processor request, held high until `cpu_done` |
| cpu_wr | input | NCPU | Per-processor request type: 1 = write, 0 = read |
| cpu_addr | input | NCPU*ADDR_W | Per-processor word address; processor i uses bits [i*ADDR_W +: ADDR_W] |
| cpu_wdata | input | NCPU*DATA_W | Per-processor write data; processor i uses bits [i*DATA_W +: DATA_W] |
| cpu_done | output | NCPU | One-cycle completion pulse per processor |
| cpu_hit | output | NCPU | Valid when `cpu_done` is high: 1 if the access found the line in the local cache |
| cpu_rdata | output | NCPU*DATA_W | Valid when `cpu_done` is high: read data, or for a write the data written |

## Verification
The tests cover four kinds of access pattern, and each one separates a different pair of behaviours:
- **Single-processor read streams** separate a cold miss from a repeated hit, and a line replacement (same index, different tag) from a true hit.
- **Sequences where several processors read an address before one of them writes it** separate correct invalidation, which turns into a miss carrying the new value, from a stale hit. They also separate the writer's own updated copy from the invalidated copies.
- **A write whose completion is timed to land in the same cycle as another processor's hitting read** separates invalidation priority from a stale hit.
- **Writes to a different tag at the same index, and simultaneous requests from two processors**, separate exact tag matching from index-only matching, and serialised arbitration from lost transfers.

// File: rtl/coh_pkg.sv
package coh_pkg;
    parameter int unsigned NCPU    = 3;
    parameter int unsigned ADDR_W  = 6;
    parameter int unsigned IDX_W   = 2;
    parameter int unsigned DATA_W  = 8;
    parameter int unsigned MEM_LAT = 2;

    localparam int unsigned TAG_W     = ADDR_W - IDX_W;
    localparam int unsigned LINES     = 1 << IDX_W;
    localparam int unsigned MEM_WORDS = 1 << ADDR_W;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_BUS  = 2'd1,
        C_DONE = 2'd2
    } cache_st_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic logic [IDX_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] gnt
);
    localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] next_ptr;

    always_comb begin
        gnt      = '0;
        next_ptr = ptr;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (req[j]) begin
                gnt      = '0;
                gnt[j]   = 1'b1;
                next_ptr = PTR_W'((j + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take && |req) begin
            ptr <= next_ptr;
        end
    end

    assert_gnt_single_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    assert_gnt_from_req_R10: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/coh_bus_mem.sv
module coh_bus_mem
    import coh_pkg::*;
#(
    parameter int unsigned N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      req,
    input  bus_cmd_t          cmd [N],
    output logic [N-1:0]      ack,
    output logic              fire,
    output bus_cmd_t          cur,
    output logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned CNT_W = $clog2(MEM_LAT) + 1;

    logic [DATA_W-1:0] mem [MEM_WORDS];
    logic [N-1:0]      owner;
    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [N-1:0]      gnt;
    logic              take;

    assign take = !busy;

    rr_arbiter #(.N(N)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .take (take),
        .gnt  (gnt)
    );

    always_comb begin
        cur = '0;
        for (int i = 0; i < N; i++) begin
            if (owner[i]) cur = cur | cmd[i];
        end
    end

    assign fire      = busy && (cnt == CNT_W'(MEM_LAT - 1));
    assign ack       = fire ? owner : '0;
    assign mem_rdata = mem[cur.addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            cnt   <= '0;
            for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
        end else if (!busy) begin
            if (|req) begin
                busy  <= 1'b1;
                owner <= gnt;
                cnt   <= '0;
            end
        end else begin
            if (fire) begin
                busy  <= 1'b0;
                owner <= '0;
                if (cur.wr) mem[cur.addr] <= cur.wdata;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_one_owner_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && cur.wr) |=> (mem[$past(cur.addr)] == $past(cur.wdata)));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
    import coh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bus_cmd_t          bus_cmd,
    input  logic              bus_ack,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [LINES-1:0]  vld;
    logic [TAG_W-1:0]  tagq [LINES];
    logic [DATA_W-1:0] datq [LINES];
    cache_st_t         st;
    bus_cmd_t          cmd_q;
    logic              hit_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0] lidx, sidx, cidx;
    logic             lookup, snoop_kill, hit_eff, own_present;

    assign lidx        = line_of(cpu_addr);
    assign sidx        = line_of(snp_addr);
    assign cidx        = line_of(cmd_q.addr);
    assign lookup      = vld[lidx] && (tagq[lidx] == tag_of(cpu_addr));
    assign snoop_kill  = snp_valid && vld[sidx] && (tagq[sidx] == tag_of(snp_addr));
    assign hit_eff     = lookup && !(snoop_kill && (sidx == lidx));
    assign own_present = vld[cidx] && (tagq[cidx] == tag_of(cmd_q.addr));

    assign cpu_done  = (st == C_DONE);
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;
    assign bus_req   = (st == C_BUS);
    assign bus_cmd   = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= '0;
            st      <= C_IDLE;
            cmd_q   <= '0;
            hit_q   <= 1'b0;
            rdata_q <= '0;
            for (int l = 0; l < LINES; l++) begin
                tagq[l] <= '0;
                datq[l] <= '0;
            end
        end else begin
            if (snoop_kill) vld[sidx] <= 1'b0;
            case (st)
                C_IDLE: if (cpu_valid) begin
                    cmd_q <= '{wr: cpu_wr, addr: cpu_addr, wdata: cpu_wdata};
                    hit_q <= hit_eff;
                    if (!cpu_wr && hit_eff) begin
                        rdata_q <= datq[lidx];
                        st      <= C_DONE;
                    end else begin
                        st <= C_BUS;
                    end
                end
                C_BUS: if (bus_ack) begin
                    if (cmd_q.wr) begin
                        if (own_present) datq[cidx] <= cmd_q.wdata;
                        rdata_q <= cmd_q.wdata;
                    end else begin
                        vld[cidx]  <= 1'b1;
                        tagq[cidx] <= tag_of(cmd_q.addr);
                        datq[cidx] <= mem_rdata;
                        rdata_q    <= mem_rdata;
                    end
                    st <= C_DONE;
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    assert_snoop_clears_R5: assert property (@(posedge clk) disable iff (rst)
        snoop_kill |=> !vld[$past(sidx)]);
    assert_fill_sets_line_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !cmd_q.wr) |=> vld[$past(cidx)]);
    assert_hold_request_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd)));
    assert_kill_beats_hit_R8: assert property (@(posedge clk) disable iff (rst)
        (st == C_IDLE && cpu_valid && !cpu_wr && lookup && snoop_kill && sidx == lidx)
        |=> (!cpu_done && !cpu_hit));
endmodule

// File: rtl/coh_wt_cluster.sv
module coh_wt_cluster
    import coh_pkg::*;
#(
    parameter int unsigned N = coh_pkg::NCPU
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          cpu_valid,
    input  logic [N-1:0]          cpu_wr,
    input  logic [N*ADDR_W-1:0]   cpu_addr,
    input  logic [N*DATA_W-1:0]   cpu_wdata,
    output logic [N-1:0]          cpu_done,
    output logic [N-1:0]          cpu_hit,
    output logic [N*DATA_W-1:0]   cpu_rdata
);
    logic [N-1:0]      bus_req;
    logic [N-1:0]      bus_ack;
    bus_cmd_t          cmd [N];
    bus_cmd_t          cur;
    logic              fire;
    logic [DATA_W-1:0] mem_rdata;

    coh_bus_mem #(.N(N)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .req       (bus_req),
        .cmd       (cmd),
        .ack       (bus_ack),
        .fire      (fire),
        .cur       (cur),
        .mem_rdata (mem_rdata)
    );

    for (genvar i = 0; i < N; i++) begin : g_cache
        logic snp_valid;
        assign snp_valid = fire && cur.wr && !bus_ack[i];

        wt_snoop_cache u_cache (
            .clk       (clk),
            .rst       (rst),
            .cpu_valid (cpu_valid[i]),
            .cpu_wr    (cpu_wr[i]),
            .cpu_addr  (cpu_addr[i*ADDR_W +: ADDR_W]),
            .cpu_wdata (cpu_wdata[i*DATA_W +: DATA_W]),
            .cpu_done  (cpu_done[i]),
            .cpu_hit   (cpu_hit[i]),
            .cpu_rdata (cpu_rdata[i*DATA_W +: DATA_W]),
            .bus_req   (bus_req[i]),
            .bus_cmd   (cmd[i]),
            .bus_ack   (bus_ack[i]),
            .snp_valid (snp_valid),
            .snp_addr  (cur.addr),
            .mem_rdata (mem_rdata)
        );
    end
endmodule

// File: tb/tb_coh_wt_cluster.sv
module tb_coh_wt_cluster;
    import coh_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC         = NCPU;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NC-1:0]        cpu_valid = '0;
    logic [NC-1:0]        cpu_wr = '0;
    logic [NC*ADDR_W-1:0] cpu_addr = '0;
    logic [NC*DATA_W-1:0] cpu_wdata = '0;
    logic [NC-1:0]        cpu_done;
    logic [NC-1:0]        cpu_hit;
    logic [NC*DATA_W-1:0] cpu_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    typedef struct {
        int                cpu;
        logic [DATA_W-1:0] data;
        bit                hit;
        string             tag;
    } exp_t;
    exp_t expq[$];

    coh_wt_cluster dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_done  (cpu_done),
        .cpu_hit   (cpu_hit),
        .cpu_rdata (cpu_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Driver: pushes the expected result into the scoreboard, then issues
    // the request and holds it until the completion pulse is seen.
    task automatic op(input int c, input bit wr, input int a, input int wd,
                      input int ed, input bit eh, input string tag);
        exp_t e;
        e.cpu = c;
        e.data = DATA_W'(ed);
        e.hit = eh;
        e.tag = tag;
        expq.push_back(e);
        cpu_valid[c] = 1'b1;
        cpu_wr[c] = wr;
        cpu_addr[c*ADDR_W +: ADDR_W] = ADDR_W'(a);
        cpu_wdata[c*DATA_W +: DATA_W] = DATA_W'(wd);
        do @(negedge clk); while (!cpu_done[c]);
        cpu_valid[c] = 1'b0;
    endtask

    // Monitor: matches each completion pulse against the oldest expected
    // item for that processor.
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NC; c++) begin
                if (cpu_done[c]) begin
                    int k;
                    k = -1;
                    for (int q = 0; q < expq.size(); q++) begin
                        if (k < 0 && expq[q].cpu == c) k = q;
                    end
                    n_chk++;
                    if (k < 0) begin
                        n_fail++;
                        $display("FAIL unexpected completion on cpu%0d: actual data=%0d hit=%0d expected none",
                                 c, cpu_rdata[c*DATA_W +: DATA_W], cpu_hit[c]);
                    end else begin
                        if (cpu_rdata[c*DATA_W +: DATA_W] !== expq[k].data ||
                            cpu_hit[c] !== expq[k].hit) begin
                            n_fail++;
                            $display("FAIL %s cpu%0d: actual data=%0d hit=%0d expected data=%0d hit=%0d",
                                     expq[k].tag, c, cpu_rdata[c*DATA_W +: DATA_W], cpu_hit[c],
                                     expq[k].data, expq[k].hit);
                        end
                        expq.delete(k);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected completion earlier", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (cpu_done !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: actual done=%b expected 0", cpu_done);
        end

        // Cold miss, then a repeated hit.
        op(0, 0, 1, 0, 0, 0, "R1 cold read");
        op(0, 0, 1, 0, 0, 1, "R2 repeat read hit");
        // Addresses 5 and 1 share index 1 with different tags.
        op(0, 0, 5, 0, 0, 0, "R9 conflict read");
        op(0, 0, 1, 0, 0, 0, "R9 replaced line");
        // A write miss does not allocate; memory receives the value.
        op(0, 1, 8, 20, 20, 0, "R7 write miss");
        op(0, 0, 8, 0, 20, 0, "R7 no allocate / R4 memory");
        // Shared clean copies.
        op(1, 0, 8, 0, 20, 0, "R3 cpu1 fill");
        op(2, 0, 8, 0, 20, 0, "R3 cpu2 fill");
        op(1, 0, 8, 0, 20, 1, "R3 cpu1 shared hit");
        op(2, 0, 8, 0, 20, 1, "R3 cpu2 shared hit");
        // Write invalidates the others; the writer keeps an updated copy.
        op(0, 1, 8, 40, 40, 1, "R7 write hit");
        op(0, 0, 8, 0, 40, 1, "R6 writer keeps copy");
        op(1, 0, 8, 0, 40, 0, "R5 cpu1 invalidated");
        op(2, 0, 8, 0, 40, 0, "R5 cpu2 invalidated");
        // Same index, different tag: no invalidation.
        op(1, 0, 1, 0, 0, 0, "R11 cpu1 fill addr1");
        op(0, 1, 5, 7, 7, 0, "R11 write addr5");
        op(1, 0, 1, 0, 0, 1, "R11 cpu1 still valid");
        op(2, 0, 5, 0, 7, 0, "R4 cpu2 reads written word");
        // cpu1 read lands in the same cycle as cpu0's write completion:
        // request at negedge k, grant at edge k+2, ack in cycle k+3..k+4.
        fork
            op(0, 1, 8, 55, 55, 1, "R8 writer");
            begin
                repeat (3) @(negedge clk);
                op(1, 0, 8, 0, 55, 0, "R8 invalidation beats hit");
            end
        join
        op(1, 0, 8, 0, 55, 1, "R8 refilled line");
        // Simultaneous requests are serialised and all complete.
        fork
            op(1, 1, 2, 11, 11, 0, "R10 cpu1 write");
            op(2, 1, 3, 12, 12, 0, "R10 cpu2 write");
        join
        op(0, 0, 2, 0, 11, 0, "R10 first write kept");
        op(0, 0, 3, 0, 12, 0, "R10 second write kept");
        fork
            op(1, 0, 2, 0, 11, 0, "R10 cpu1 read");
            op(2, 0, 2, 0, 11, 0, "R10 cpu2 read");
            op(0, 0, 2, 0, 11, 1, "R10 cpu0 hit");
        join

        repeat (2) @(negedge clk);
        n_chk++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL R10 pending: actual outstanding=%0d expected 0", expq.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule